// File: doc/BRIEF.md
# Circular Capture Buffer Engine

This block is the storage core of an on-chip logic analyzer. Once armed, it writes one 64-bit sample word into an internal memory on every sample strobe. Writes go to a window that starts at a programmable word address and spans a programmable number of words. When the write pointer reaches the end of the window it returns to the window start and keeps writing, so the window behaves as a ring that always holds the most recent samples.

A trigger comes either from a hardware pulse or from a rising edge on a software-driven level. After the trigger, capture continues until an external post-trigger-expired pulse arrives. Capture then stops and the block raises a done bit for the selected trigger source. A 32-bit status word holds three things: a sticky wrap flag, the address of the last written word, and the done bits. From these a host can find the oldest sample and read the ring back in time order through a one-cycle-latency readout port. Addresses are counted in 8-byte words.

Top module: `cap_ring_top`

## Requirements
- R1: After reset the status word is all zero and `rd_valid` is 0.
- R2: A cycle with `arm` high clears the wrap flag and both done bits, sets the finish field to `cfg_start`, and starts capture. A strobe in that same cycle is not stored.
- R3: While capturing, each cycle with `smp_valid` high stores `smp_data` at the write pointer, and the finish field (status bits 30:16) then shows that word's address. Without a strobe the finish field does not change.
- R4: The window covers addresses `cfg_start` through `cfg_start+cfg_size-1`. A write at the last address sends the next write to `cfg_start` and sets status bit 31, which stays set until the next arm.
- R5: A `trig_hw` pulse, or a 0-to-1 change of `trig_sw`, moves capture from pre-trigger to post-trigger. A `trig_sw` level that is held high is not a trigger.
- R6: A `post_expired` pulse after a trigger stops capture, and a strobe in that same cycle is still stored. A `post_expired` pulse before any trigger has no effect.
- R7: On stop, status bit 1 is set if `src_sel` is 0 (baseband source) or status bit 2 if `src_sel` is 1 (MAC source). At most one of the two is ever set.
- R8: After stop, strobes are ignored: the status word and the stored words stay unchanged until the next arm.
- R9: A `rd_req` while a done bit is set makes `rd_valid` 1 in the next cycle, with `rd_data` equal to the word at address `rd_idx`. A `rd_req` while no done bit is set leaves `rd_valid` at 0.
- R10: After a stop, reading the ring oldest-first returns the samples in capture order. If the ring has wrapped, this read starts at finish+1 (wrapping to `cfg_start`) and covers `cfg_size` words. If it has not wrapped, it starts at `cfg_start` and ends at the finish address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm | input | 1 | Clear status and start a new capture |
| cfg_start | input | ADDR_W | Window start, in 8-byte words |
| cfg_size | input | ADDR_W+1 | Window size in words (at least 2, start+size within depth) |
| src_sel | input | 1 | Trigger source, chooses which done bit is set: 0 baseband, 1 MAC |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DATA_W | Sample word |
| trig_hw | input | 1 | Hardware trigger pulse |
| trig_sw | input | 1 | Software trigger level; its rising edge triggers |
| post_expired | input | 1 | Post-trigger interval elapsed |
| rd_req | input | 1 | Readout request |
| rd_idx | input | ADDR_W | Readout word address |
| rd_valid | output | 1 | Readout data valid (one cycle after request) |
| rd_data | output | DATA_W | Readout word |
| stat_word | output | 32 | Bit 31 wrap, 30:16 finish address, bit 2 MAC done, bit 1 baseband done |

## Verification
The assertions check on every cycle that the wrap flag stays set once raised and that at most one done bit is set. They also check that the status word is frozen after a stop, that the finish field moves only on a strobe, that arming clears status, and the readout handshake in both the done and not-done states. Only the bench scenarios can show which data landed at which address, where the pointer wraps for a given window, and whether trigger edges and pre-trigger expiry pulses are handled correctly. They also show that an oldest-first readout rebuilds the capture order for both wrapped and unwrapped rings.

// File: rtl/cap_ring_pkg.sv
// Package: shared types and status-word layout for the capture ring.
// Assumes the finish field is wide enough for the word address (ADDR_W <= 15).
package cap_ring_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_POST = 2'd2,
        ST_STOP = 2'd3
    } cap_state_e;

    localparam int STAT_W   = 32;
    localparam int WRAP_BIT = 31;
    localparam int FIN_LSB  = 16;
    localparam int FIN_W    = 15;
    localparam int DONE_LSB = 1;
    localparam int NSRC     = 2;
endpackage

// File: rtl/cap_ctrl.sv
// Capture sequencer: idle -> pre-trigger -> post-trigger -> stopped.
// Detects software trigger edges and keeps one done bit per trigger source.
// Assumes arm has priority over every other input in the same cycle.
module cap_ctrl
    import cap_ring_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arm,
    input  logic            src_sel,
    input  logic            trig_hw,
    input  logic            trig_sw,
    input  logic            post_expired,
    output logic            wr_allow,
    output logic [NSRC-1:0] done
);
    cap_state_e state;
    logic       sw_q;
    logic       trig_evt;
    logic       stop_evt;

    assign trig_evt = trig_hw | (trig_sw & ~sw_q);
    assign stop_evt = (state == ST_POST) & post_expired & ~arm;
    assign wr_allow = (state == ST_PRE) | (state == ST_POST);

    // Remember last software trigger level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sw_q <= 1'b0;
        else        sw_q <= trig_sw;
    end

    // Sequencer state transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else if (arm) begin
            state <= ST_PRE;
        end else begin
            case (state)
                ST_PRE:  if (trig_evt)     state <= ST_POST;
                ST_POST: if (post_expired) state <= ST_STOP;
                default: state <= state;
            endcase
        end
    end

    // One sticky done bit per trigger source.
    for (genvar s = 0; s < NSRC; s++) begin : g_done
        always_ff @(posedge clk) begin
            if (!rst_n || arm)                          done[s] <= 1'b0;
            else if (stop_evt && (int'(src_sel) == s))  done[s] <= 1'b1;
        end
    end
endmodule

// File: rtl/cap_wptr.sv
// Write pointer for the ring window: advances per stored word, wraps at
// start+size back to start, tracks the last written address and a sticky
// wrap flag. Assumes cfg_start/cfg_size are stable while capturing.
module cap_wptr #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] cfg_start,
    input  logic [ADDR_W:0]   cfg_size,
    output logic [ADDR_W-1:0] wp,
    output logic [ADDR_W-1:0] fin,
    output logic              wrap
);
    logic [ADDR_W:0] end_ext;
    logic [ADDR_W:0] nxt_ext;
    logic            at_end;

    assign end_ext = {1'b0, cfg_start} + cfg_size;
    assign nxt_ext = {1'b0, wp} + (ADDR_W+1)'(1);
    assign at_end  = (nxt_ext == end_ext);

    // Pointer, finish address and wrap flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp   <= '0;
            fin  <= '0;
            wrap <= 1'b0;
        end else if (arm) begin
            wp   <= cfg_start;
            fin  <= cfg_start;
            wrap <= 1'b0;
        end else if (wr_en) begin
            fin <= wp;
            if (at_end) begin
                wp   <= cfg_start;
                wrap <= 1'b1;
            end else begin
                wp   <= nxt_ext[ADDR_W-1:0];
            end
        end
    end
endmodule

// File: rtl/cap_mem.sv
// Sample store: single write port, registered read port with one-cycle
// latency. Assumes reads and writes never target the same cycle.
module cap_mem #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store a sample word.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Registered readout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= mem[rd_addr];
        end
    end
endmodule

// File: rtl/cap_ring_top.sv
// Circular capture buffer top: ties sequencer, write pointer and sample
// store together and assembles the status word.
// Assumes 2 <= cfg_size and cfg_start+cfg_size <= 2**ADDR_W, ADDR_W <= 15.
module cap_ring_top
    import cap_ring_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic [ADDR_W-1:0] cfg_start,
    input  logic [ADDR_W:0]   cfg_size,
    input  logic              src_sel,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              trig_hw,
    input  logic              trig_sw,
    input  logic              post_expired,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_idx,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [31:0]       stat_word
);
    logic              wr_allow;
    logic [NSRC-1:0]   done;
    logic              wr_en;
    logic              rd_en;
    logic [ADDR_W-1:0] wp;
    logic [ADDR_W-1:0] fin;
    logic              wrap;

    assign wr_en = smp_valid & wr_allow & ~arm;
    assign rd_en = rd_req & (|done) & ~arm;

    cap_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .arm          (arm),
        .src_sel      (src_sel),
        .trig_hw      (trig_hw),
        .trig_sw      (trig_sw),
        .post_expired (post_expired),
        .wr_allow     (wr_allow),
        .done         (done)
    );

    cap_wptr #(.ADDR_W(ADDR_W)) u_wptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .wr_en     (wr_en),
        .cfg_start (cfg_start),
        .cfg_size  (cfg_size),
        .wp        (wp),
        .fin       (fin),
        .wrap      (wrap)
    );

    cap_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wp),
        .wr_data  (smp_data),
        .rd_en    (rd_en),
        .rd_addr  (rd_idx),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    // Status word assembly.
    always_comb begin
        stat_word = '0;
        stat_word[WRAP_BIT] = wrap;
        stat_word[FIN_LSB +: ADDR_W] = fin;
        stat_word[DONE_LSB +: NSRC] = done;
    end
endmodule

// File: rtl/cap_ring_chk.sv
// Checker for cap_ring_top: port-level temporal properties, bound below.
module cap_ring_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              arm,
    input logic [ADDR_W-1:0] cfg_start,
    input logic              smp_valid,
    input logic              rd_req,
    input logic              rd_valid,
    input logic [31:0]       stat_word
);
    logic any_done;
    assign any_done = stat_word[1] | stat_word[2];

    AST_RST_CLEAR: assert property (@(posedge clk) !rst_n |=> (stat_word == 32'd0 && !rd_valid)); // R1
    AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (!stat_word[31] && stat_word[2:1] == 2'b00 && stat_word[16 +: ADDR_W] == $past(cfg_start))); // R2
    AST_FIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_valid && !arm) |=> $stable(stat_word[30:16])); // R3
    AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_word[31] && !arm) |=> stat_word[31]); // R4
    AST_DONE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stat_word[2:1])); // R7
    AST_STOP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (any_done && !arm) |=> $stable(stat_word)); // R8
    AST_RD_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && any_done && !arm) |=> rd_valid); // R9
    AST_RD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!(rd_req && any_done)) |=> !rd_valid); // R9
endmodule

bind cap_ring_top cap_ring_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (arm),
    .cfg_start (cfg_start),
    .smp_valid (smp_valid),
    .rd_req    (rd_req),
    .rd_valid  (rd_valid),
    .stat_word (stat_word)
);

// File: tb/cap_ring_top_tb.sv
`timescale 1ns/1ps
module cap_ring_top_tb;
    localparam int AW = 6;
    localparam int DW = 64;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          arm = 1'b0;
    logic [AW-1:0] cfg_start = '0;
    logic [AW:0]   cfg_size = '0;
    logic          src_sel = 1'b0;
    logic          smp_valid = 1'b0;
    logic [DW-1:0] smp_data = '0;
    logic          trig_hw = 1'b0;
    logic          trig_sw = 1'b0;
    logic          post_expired = 1'b0;
    logic          rd_req = 1'b0;
    logic [AW-1:0] rd_idx = '0;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic [31:0]   stat_word;

    int total = 0;
    int bad = 0;

    // bench model of the ring, driven from the requirements
    logic [DW-1:0] em [DEPTH];
    int   m_start, m_end, m_wp, m_fin;
    bit   m_wrap, m_active, m_trig, m_bb, m_mac, m_sw;

    cap_ring_top #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .cfg_start(cfg_start),
        .cfg_size(cfg_size), .src_sel(src_sel), .smp_valid(smp_valid),
        .smp_data(smp_data), .trig_hw(trig_hw), .trig_sw(trig_sw),
        .post_expired(post_expired), .rd_req(rd_req), .rd_idx(rd_idx),
        .rd_valid(rd_valid), .rd_data(rd_data), .stat_word(stat_word)
    );

    always #4 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_stat();
        logic [31:0] s;
        s = '0;
        s[31] = m_wrap;
        s[16 +: AW] = AW'(m_fin);
        s[1] = m_bb;
        s[2] = m_mac;
        return s;
    endfunction

    function automatic int ring_next(int a);
        return (a + 1 == m_end) ? m_start : a + 1;
    endfunction

    task automatic model_store(logic [DW-1:0] d);
        em[m_wp] = d;
        m_fin = m_wp;
        if (m_wp + 1 == m_end) begin
            m_wp = m_start;
            m_wrap = 1'b1;
        end else begin
            m_wp = m_wp + 1;
        end
    endtask

    task automatic do_arm(int st, int sz, bit src, bit with_smp);
        arm = 1'b1; cfg_start = AW'(st); cfg_size = (AW+1)'(sz); src_sel = src;
        smp_valid = with_smp; smp_data = 64'hDEAD_0000_0000_BEEF;
        tick();
        arm = 1'b0; smp_valid = 1'b0;
        m_start = st; m_end = st + sz; m_wp = st; m_fin = st;
        m_wrap = 0; m_active = 1; m_trig = 0; m_bb = 0; m_mac = 0;
    endtask

    task automatic sample(logic [DW-1:0] d);
        smp_valid = 1'b1; smp_data = d;
        tick();
        smp_valid = 1'b0;
        if (m_active) model_store(d);
    endtask

    task automatic hw_trig();
        trig_hw = 1'b1;
        tick();
        trig_hw = 1'b0;
        if (m_active) m_trig = 1;
    endtask

    task automatic sw_level(bit v);
        trig_sw = v;
        tick();
        if (m_active && v && !m_sw) m_trig = 1;
        m_sw = v;
    endtask

    task automatic expire(bit with_smp, logic [DW-1:0] d);
        post_expired = 1'b1; smp_valid = with_smp; smp_data = d;
        tick();
        post_expired = 1'b0; smp_valid = 1'b0;
        if (m_active) begin
            if (with_smp) model_store(d);
            if (m_trig) begin
                m_active = 0;
                if (src_sel) m_mac = 1; else m_bb = 1;
            end
        end
    endtask

    task automatic rd_one(int a, string req);
        rd_req = 1'b1; rd_idx = AW'(a);
        tick();
        rd_req = 1'b0;
        chk({req, " rd_valid"}, 64'(rd_valid), 64'd1);
        chk({req, " rd_data"}, rd_data, em[a]);
    endtask

    // oldest-first readout of the whole captured ring
    task automatic read_ring(string req);
        int a, n;
        if (m_wrap) begin a = ring_next(m_fin); n = m_end - m_start; end
        else begin a = m_start; n = m_fin - m_start + 1; end
        for (int k = 0; k < n; k++) begin
            rd_one(a, req);
            a = ring_next(a);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] snap;
        void'($urandom(32'd20240611));
        m_sw = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 stat", 64'(stat_word), 64'd0);
        chk("R1 rd_valid", 64'(rd_valid), 64'd0);
        rst_n = 1'b1;
        tick();

        // R2: arm clears and ignores a same-cycle strobe
        do_arm(8, 16, 1'b0, 1'b1);
        chk("R2 stat after arm", 64'(stat_word), 64'(exp_stat()));
        // R9: read before done is blocked
        rd_req = 1'b1; rd_idx = AW'(8);
        tick();
        rd_req = 1'b0;
        chk("R9 read blocked", 64'(rd_valid), 64'd0);

        // R3: samples without wrap
        for (int i = 0; i < 5; i++) sample(64'h1111_0000_0000_0000 + 64'(i));
        chk("R3 finish", 64'(stat_word), 64'(exp_stat()));
        // R6: expiry before trigger ignored
        expire(1'b0, '0);
        chk("R6 early expiry", 64'(stat_word), 64'(exp_stat()));
        hw_trig();
        for (int i = 0; i < 2; i++) sample(64'h2222_0000_0000_0000 + 64'(i));
        expire(1'b1, 64'h3333_3333_3333_3333);
        // R6, R7: stop with baseband done, expiry-cycle sample stored
        chk("R7 bb done", 64'(stat_word), 64'(exp_stat()));
        chk("R6 finish incl expiry sample", 64'(stat_word[30:16]), 64'd15);
        snap = stat_word;
        // R8: strobes after stop ignored
        for (int i = 0; i < 4; i++) sample(64'hBAD0_0000_0000_0000 + 64'(i));
        chk("R8 status frozen", 64'(stat_word), 64'(snap));
        read_ring("R10 unwrapped");
        rd_one(16, "R8 word beyond finish");

        // R5: held software level is not a trigger
        m_sw = trig_sw;
        sw_level(1'b1);
        do_arm(4, 10, 1'b1, 1'b0);
        for (int i = 0; i < 27; i++) sample({$urandom, $urandom});
        expire(1'b0, '0);
        chk("R5 held level no trigger", 64'(stat_word[2:1]), 64'd0);
        sw_level(1'b0);
        sw_level(1'b1);
        sample(64'h4444_4444_4444_4444);
        expire(1'b0, '0);
        // R4, R7: wrapped capture, MAC done
        chk("R4 wrap status", 64'(stat_word), 64'(exp_stat()));
        chk("R4 wrap bit", 64'(stat_word[31]), 64'd1);
        chk("R7 mac done", 64'(stat_word[2:1]), 64'd2);
        read_ring("R10 wrapped");

        // exact-fill boundary: size words, wrap at last write
        do_arm(0, 4, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) sample(64'h5555_0000_0000_0000 + 64'(i));
        chk("R4 exact fill wraps", 64'(stat_word), 64'(exp_stat()));
        hw_trig();
        expire(1'b0, '0);
        read_ring("R10 exact fill");

        // randomized runs
        for (int r = 0; r < 8; r++) begin
            int st, sz, pre, post;
            st = $urandom_range(0, 40);
            sz = $urandom_range(2, DEPTH - st);
            pre = $urandom_range(1, 3 * sz);
            post = $urandom_range(0, sz);
            do_arm(st, sz, 1'($urandom_range(0, 1)), 1'b0);
            for (int i = 0; i < pre; i++) begin
                if ($urandom_range(0, 3) == 0) tick();
                sample({$urandom, $urandom});
            end
            if ($urandom_range(0, 1) == 1) hw_trig();
            else begin sw_level(1'b0); sw_level(1'b1); end
            for (int i = 0; i < post; i++) sample({$urandom, $urandom});
            expire(1'b1, {$urandom, $urandom});
            chk("R3 random status", 64'(stat_word), 64'(exp_stat()));
            read_ring("R10 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule